// File: doc/BRIEF.md
# Multi-Master I2C Clock Synchronizer and Arbitration Core

This block is the bus-timing engine of an I2C master that shares its bus with other masters. It drives the open-drain SCL and SDA wires only through pull-down enables and reads the true wire levels back through a synchronizer. While a run request is held, it produces SCL from two programmable counts of system clocks: one for the low phase and one for the high phase. It does not run free. It follows the wired-AND line, so the slowest master sets the low phase and the fastest master ends the high phase.

Once in every high phase, the block gives a one-cycle bit strobe. If it is sending a 1 and reads a 0 on SDA at that point, it has lost arbitration. It then releases both wires, returns to slave-receive mode without producing a STOP, and raises a sticky flag that stays set until it is cleared. Byte framing, addressing, acknowledge handling and START/STOP generation belong to the layer that uses this block.

Top module: `mm_scl_arb`

## Requirements
- R1: After reset, scl_oe, sda_oe, arb_lost, master_mode and bit_strobe are all 0.
- R2: When run_req is 1, arb_lost is 0 and the block is idle, the next clock edge sets master_mode to 1 and scl_oe to 1, so SCL is pulled low.
- R3: The block pulls SCL low until it has counted low_cycles system clocks. Counting starts when the synchronized falling edge of SCL is seen. With a two-flop synchronizer and no other master on the bus, SCL therefore stays low for low_cycles+3 clocks.
- R4: After its low count, the block releases SCL and waits while the line still reads low. Its high count starts only on the first clock on which the synchronized line reads high. When another master holds SCL low for longer, the low phase lasts as long as that master holds it.
- R5: The block counts high_cycles system clocks and then pulls SCL low again. With no other master, the high phase lasts high_cycles+3 clocks.
- R6: If a falling edge on SCL is seen during the high count, the high phase ends at once and the low count restarts from that edge. When another master pulls SCL low during the high phase, the line stays low for low_cycles+2 clocks from that moment.
- R7: bit_strobe is a one-clock pulse. It appears once in each counted high phase, on the fourth clock of SCL high (the first clock of the high count).
- R8: sda_oe is 1 exactly when master_mode, tx_active are 1 and tx_bit is 0. So a 0 pulls SDA low and a 1 releases it.
- R9: On a bit_strobe clock with tx_active=1, tx_bit=1 and synchronized SDA low, the next clock sets arb_lost to 1 and clears master_mode, scl_oe and sda_oe. When tx_bit is 0, when tx_active is 0, or when SDA reads high, nothing is lost.
- R10: A loss of arbitration produces no STOP. SDA is already released in the clock that detects the loss and stays released afterwards. SCL is left released, and the block produces no further SCL edges.
- R11: arb_lost stays 1 until arb_clear is 1. While arb_lost is 1, run_req does not start the block. The clock after arb_lost clears, a held run_req starts it again.
- R12: When run_req is 0 at the end of a high count, the block returns to idle with SCL released and master_mode at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_req | input | 1 | Keep generating SCL as master while 1 |
| tx_bit | input | 1 | Bit value being sent on SDA |
| tx_active | input | 1 | 1 while this master sends on SDA |
| low_cycles | input | CNT_W | SCL low-phase length in system clocks |
| high_cycles | input | CNT_W | SCL high-phase length in system clocks |
| arb_clear | input | 1 | Clears the arbitration-lost flag |
| scl_in | input | 1 | Sampled level of the SCL wire |
| sda_in | input | 1 | Sampled level of the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| bit_strobe | output | 1 | One-clock pulse at the bit sample point of each high phase |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| master_mode | output | 1 | 1 in master mode, 0 in slave-receive (idle) mode |

## Verification
The assertions assume that scl_in and sda_in are the wired-AND of this block's own enables and the other devices' drive. In particular, whenever scl_oe is 1 the line reads low, so a high synchronized SCL never appears during the block's own low count. They also assume that the period counts are at least 1 and are not changed within the clocks a property spans. The bench models the bus as exactly that wired-AND of the block's enables and the enables of a scripted second master. It changes tx_bit and tx_active and the second master's SDA only during SCL low phases. It reprograms the counts only while the clock is running and checks only phases that begin after the change.

// File: rtl/mm_scl_pkg.sv
package mm_scl_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LOW   = 2'd1,
      PH_HWAIT = 2'd2,
      PH_HIGH  = 2'd3
   } phase_t;

   localparam int unsigned LINE_SCL = 0;
   localparam int unsigned LINE_SDA = 1;
   localparam int unsigned N_LINES  = 2;

endpackage

// File: rtl/mm_scl_linesync.sv
module mm_scl_linesync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw,
   output logic [LINES-1:0] sync,
   output logic [LINES-1:0] fall,
   output logic [LINES-1:0] rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mm_scl_linesync: STAGES must be at least 2");
   end
   if (LINES < 1) begin : g_bad_lines
      $error("mm_scl_linesync: LINES must be at least 1");
   end

   for (genvar ln = 0; ln < LINES; ln++) begin : g_line
      logic [STAGES-1:0] chain;
      logic              prev;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
         end else begin
            chain <= {chain[STAGES-2:0], raw[ln]};
            prev  <= chain[STAGES-1];
         end
      end

      assign sync[ln] = chain[STAGES-1];
      assign fall[ln] = prev & ~chain[STAGES-1];
      assign rise[ln] = ~prev & chain[STAGES-1];
   end

endmodule

// File: rtl/mm_scl_timer.sv
module mm_scl_timer
   import mm_scl_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_ok,
   input  logic             run_req,
   input  logic             lose,
   input  logic             scl_s,
   input  logic             scl_fall,
   input  logic [CNT_W-1:0] low_cfg,
   input  logic [CNT_W-1:0] high_cfg,
   output phase_t           phase,
   output logic [CNT_W-1:0] cnt,
   output logic             scl_pull,
   output logic             strobe
);

   localparam int unsigned EXT_W = CNT_W + 1;

   logic [EXT_W-1:0] cnt_p1;
   logic             low_done;
   logic             high_done;
   logic             first_high;

   assign cnt_p1    = {1'b0, cnt} + EXT_W'(1);
   assign low_done  = cnt_p1 >= {1'b0, low_cfg};
   assign high_done = cnt_p1 >= {1'b0, high_cfg};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         cnt        <= '0;
         first_high <= 1'b0;
      end else begin
         first_high <= 1'b0;
         case (phase)
            PH_IDLE: begin
               cnt <= '0;
               if (start_ok) phase <= PH_LOW;
            end
            PH_LOW: begin
               if (scl_fall) begin
                  cnt <= '0;
               end else if (low_done) begin
                  cnt   <= '0;
                  phase <= PH_HWAIT;
               end else begin
                  cnt <= cnt_p1[CNT_W-1:0];
               end
            end
            PH_HWAIT: begin
               cnt <= '0;
               if (scl_s) begin
                  phase      <= PH_HIGH;
                  first_high <= 1'b1;
               end
            end
            PH_HIGH: begin
               if (lose) begin
                  cnt   <= '0;
                  phase <= PH_IDLE;
               end else if (scl_fall) begin
                  cnt   <= '0;
                  phase <= PH_LOW;
               end else if (high_done) begin
                  cnt   <= '0;
                  phase <= run_req ? PH_LOW : PH_IDLE;
               end else begin
                  cnt <= cnt_p1[CNT_W-1:0];
               end
            end
            default: begin
               cnt   <= '0;
               phase <= PH_IDLE;
            end
         endcase
      end
   end

   assign scl_pull = (phase == PH_LOW);
   assign strobe   = (phase == PH_HIGH) && first_high;

endmodule

// File: rtl/mm_scl_arbiter.sv
module mm_scl_arbiter (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic tx_active,
   input  logic tx_bit,
   input  logic sda_s,
   input  logic arb_clear,
   input  logic master,
   output logic lose,
   output logic lost_flag,
   output logic sda_pull
);

   assign lose     = strobe & tx_active & tx_bit & ~sda_s;
   assign sda_pull = master & tx_active & ~tx_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lost_flag <= 1'b0;
      end else if (lose) begin
         lost_flag <= 1'b1;
      end else if (arb_clear) begin
         lost_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/mm_scl_arb.sv
module mm_scl_arb
   import mm_scl_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic             tx_bit,
   input  logic             tx_active,
   input  logic [CNT_W-1:0] low_cycles,
   input  logic [CNT_W-1:0] high_cycles,
   input  logic             arb_clear,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic             bit_strobe,
   output logic             arb_lost,
   output logic             master_mode
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("mm_scl_arb: CNT_W must lie in 2..32");
   end

   logic [N_LINES-1:0] line_raw;
   logic [N_LINES-1:0] line_sync;
   logic [N_LINES-1:0] line_fall;
   logic [N_LINES-1:0] line_rise;

   logic             scl_sync;
   logic             scl_fall;
   logic             sda_sync;
   logic             lose;
   logic             start_ok;
   phase_t           phase;
   logic [CNT_W-1:0] cnt;

   assign line_raw[LINE_SCL] = scl_in;
   assign line_raw[LINE_SDA] = sda_in;

   mm_scl_linesync #(
      .STAGES (SYNC_STAGES),
      .LINES  (N_LINES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (line_raw),
      .sync  (line_sync),
      .fall  (line_fall),
      .rise  (line_rise)
   );

   assign scl_sync = line_sync[LINE_SCL];
   assign scl_fall = line_fall[LINE_SCL];
   assign sda_sync = line_sync[LINE_SDA];
   assign start_ok = run_req & ~arb_lost;

   mm_scl_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_ok (start_ok),
      .run_req  (run_req),
      .lose     (lose),
      .scl_s    (scl_sync),
      .scl_fall (scl_fall),
      .low_cfg  (low_cycles),
      .high_cfg (high_cycles),
      .phase    (phase),
      .cnt      (cnt),
      .scl_pull (scl_oe),
      .strobe   (bit_strobe)
   );

   assign master_mode = (phase != PH_IDLE);

   mm_scl_arbiter u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (bit_strobe),
      .tx_active (tx_active),
      .tx_bit    (tx_bit),
      .sda_s     (sda_sync),
      .arb_clear (arb_clear),
      .master    (master_mode),
      .lose      (lose),
      .lost_flag (arb_lost),
      .sda_pull  (sda_oe)
   );

endmodule

// File: rtl/mm_scl_arb_chk.sv
module mm_scl_arb_chk
   import mm_scl_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input phase_t           phase,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] low_cycles,
   input logic             scl_sync,
   input logic             scl_fall,
   input logic             sda_sync,
   input logic             bit_strobe,
   input logic             tx_active,
   input logic             tx_bit,
   input logic             arb_lost,
   input logic             arb_clear,
   input logic             master_mode,
   input logic             scl_oe,
   input logic             sda_oe
);

   AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOW && !scl_fall && ({1'b0, cnt} + 1'b1 < {1'b0, low_cycles}))
      |=> (phase == PH_LOW && scl_oe)); // R3

   AST_HWAIT_STAY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HWAIT && !scl_sync) |=> (phase == PH_HWAIT && !scl_oe)); // R4

   AST_CUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HIGH && scl_fall && !(bit_strobe && tx_active && tx_bit && !sda_sync))
      |=> (phase == PH_LOW)); // R6

   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |=> !bit_strobe); // R7

   AST_LOSS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_strobe && tx_active && tx_bit && !sda_sync)
      |=> (arb_lost && !master_mode && !scl_oe && !sda_oe)); // R9

   AST_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost) |-> (!sda_oe && !$past(sda_oe))); // R10

   AST_STICKY_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost && !arb_clear) |=> arb_lost); // R11

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost && !master_mode) |=> !master_mode); // R11

endmodule

bind mm_scl_arb mm_scl_arb_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .phase       (phase),
   .cnt         (cnt),
   .low_cycles  (low_cycles),
   .scl_sync    (scl_sync),
   .scl_fall    (scl_fall),
   .sda_sync    (sda_sync),
   .bit_strobe  (bit_strobe),
   .tx_active   (tx_active),
   .tx_bit      (tx_bit),
   .arb_lost    (arb_lost),
   .arb_clear   (arb_clear),
   .master_mode (master_mode),
   .scl_oe      (scl_oe),
   .sda_oe      (sda_oe)
);

// File: tb/mm_scl_arb_test.sv
module mm_scl_arb_test;

   localparam int CLK_PERIOD = 10;
   localparam int CW         = 16;
   localparam int WATCHDOG   = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_req = 1'b0;
   logic          tx_bit = 1'b0;
   logic          tx_active = 1'b0;
   logic [CW-1:0] low_cycles = 16'd8;
   logic [CW-1:0] high_cycles = 16'd6;
   logic          arb_clear = 1'b0;
   logic          oth_scl = 1'b0;
   logic          oth_sda = 1'b0;
   logic          scl_oe, sda_oe, bit_strobe, arb_lost, master_mode;
   logic          scl_line, sda_line;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bus monitor state
   logic mon_prev = 1'b1;
   int   run_len = 0;
   int   last_low = 0;
   int   last_high = 0;
   int   falls = 0;
   int   rises = 0;
   int   strobes = 0;
   int   strobe_idx = 0;

   assign scl_line = ~scl_oe & ~oth_scl;
   assign sda_line = ~sda_oe & ~oth_sda;

   always #(CLK_PERIOD/2) clk = ~clk;

   mm_scl_arb #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_req     (run_req),
      .tx_bit      (tx_bit),
      .tx_active   (tx_active),
      .low_cycles  (low_cycles),
      .high_cycles (high_cycles),
      .arb_clear   (arb_clear),
      .scl_in      (scl_line),
      .sda_in      (sda_line),
      .scl_oe      (scl_oe),
      .sda_oe      (sda_oe),
      .bit_strobe  (bit_strobe),
      .arb_lost    (arb_lost),
      .master_mode (master_mode)
   );

   always @(posedge clk) begin
      #1;
      if (scl_line == mon_prev) begin
         run_len = run_len + 1;
      end else begin
         if (mon_prev) last_high = run_len;
         else          last_low  = run_len;
         run_len = 1;
         if (!scl_line) falls = falls + 1;
         else           rises = rises + 1;
      end
      mon_prev = scl_line;
      if (bit_strobe) begin
         strobes = strobes + 1;
         strobe_idx = scl_line ? run_len : -1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         failures = failures + 1;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_falls(input int n);
      int target;
      target = falls + n;
      wait (falls >= target);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 scl_oe", int'(scl_oe), 0);
      chk("R1 sda_oe", int'(sda_oe), 0);
      chk("R1 arb_lost", int'(arb_lost), 0);
      chk("R1 master_mode", int'(master_mode), 0);
      chk("R1 bit_strobe", int'(bit_strobe), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_freerun;
      int s0;
      @(negedge clk);
      run_req = 1'b1;
      @(posedge clk); #1;
      chk("R2 scl_oe after start", int'(scl_oe), 1);
      chk("R2 master_mode after start", int'(master_mode), 1);
      wait_falls(1);
      s0 = strobes;
      wait_falls(3);
      chk("R3 low length L=8", last_low, 8 + 3);
      chk("R5 high length H=6", last_high, 6 + 3);
      chk("R7 strobes per period", strobes - s0, 3);
      chk("R7 strobe position in high", strobe_idx, 4);
      @(negedge clk);
      low_cycles  = 16'd12;
      high_cycles = 16'd3;
      wait_falls(3);
      chk("R3 low length L=12", last_low, 12 + 3);
      chk("R5 high length H=3", last_high, 3 + 3);
      @(negedge clk);
      low_cycles  = 16'd8;
      high_cycles = 16'd6;
      wait_falls(3);
   endtask

   task automatic t_stretch;
      wait_falls(1);
      @(negedge clk);
      oth_scl = 1'b1;
      repeat (30) @(negedge clk);
      chk("R4 own SCL released while held", int'(scl_oe), 0);
      chk("R4 master still active in wait", int'(master_mode), 1);
      oth_scl = 1'b0;
      wait_falls(1);
      chk("R4 stretched low length", last_low, 31);
      chk("R4 high counted from real rise", last_high, 6 + 2);
      wait_falls(1);
   endtask

   task automatic t_cut;
      int s0;
      s0 = strobes;
      wait (strobes >= s0 + 1);
      @(negedge clk);
      oth_scl = 1'b1;
      repeat (4) @(negedge clk);
      oth_scl = 1'b0;
      wait (scl_line == 1'b1);
      @(posedge clk); #2;
      chk("R6 cut high length", last_high, 4);
      chk("R6 low restarted from foreign edge", last_low, 8 + 2);
      wait_falls(2);
      chk("R6 normal low after cut", last_low, 8 + 3);
   endtask

   task automatic t_stop;
      int f0;
      wait_falls(1);
      @(negedge clk);
      run_req = 1'b0;
      f0 = falls;
      repeat (60) @(posedge clk);
      #1;
      chk("R12 no further falls", falls, f0);
      chk("R12 master_mode idle", int'(master_mode), 0);
      chk("R12 scl released", int'(scl_oe), 0);
      chk("R12 line high", int'(scl_line), 1);
   endtask

   task automatic t_arb;
      int s0;
      int f0;
      @(negedge clk);
      run_req = 1'b1;
      tx_active = 1'b1;
      tx_bit = 1'b0;
      @(posedge clk); #1;
      chk("R8 sda_oe for 0", int'(sda_oe), 1);
      @(negedge clk);
      tx_bit = 1'b1;
      @(posedge clk); #1;
      chk("R8 sda_oe for 1", int'(sda_oe), 0);
      @(negedge clk);
      tx_active = 1'b0;
      tx_bit = 1'b0;
      @(posedge clk); #1;
      chk("R8 sda_oe when not sending", int'(sda_oe), 0);
      // sending 1 on a free SDA wins
      wait_falls(1);
      @(negedge clk);
      tx_active = 1'b1;
      tx_bit = 1'b1;
      wait_falls(2);
      chk("R9 no loss on high SDA", int'(arb_lost), 0);
      // sending 0 while the other also sends 0
      @(negedge clk);
      tx_bit = 1'b0;
      oth_sda = 1'b1;
      wait_falls(2);
      chk("R9 no loss when sending 0", int'(arb_lost), 0);
      // receiving while SDA low
      @(negedge clk);
      tx_active = 1'b0;
      tx_bit = 1'b1;
      wait_falls(2);
      chk("R9 no loss when not sending", int'(arb_lost), 0);
      chk("R9 still master", int'(master_mode), 1);
      // losing bit
      wait_falls(1);
      @(negedge clk);
      tx_active = 1'b1;
      tx_bit = 1'b1;
      s0 = strobes;
      wait (strobes >= s0 + 1);
      chk("R10 sda released at loss point", int'(sda_oe), 0);
      @(posedge clk); #1;
      chk("R9 arb_lost set", int'(arb_lost), 1);
      chk("R9 slave mode", int'(master_mode), 0);
      chk("R10 scl released", int'(scl_oe), 0);
      chk("R10 sda released", int'(sda_oe), 0);
      f0 = falls;
      repeat (60) @(posedge clk);
      #1;
      chk("R10 no clocking after loss", falls, f0);
      chk("R11 flag sticky", int'(arb_lost), 1);
      chk("R11 run_req held no restart", int'(master_mode), 0);
      @(negedge clk);
      oth_sda = 1'b0;
      tx_active = 1'b0;
      arb_clear = 1'b1;
      @(posedge clk); #1;
      chk("R11 flag cleared", int'(arb_lost), 0);
      chk("R11 not yet restarted", int'(scl_oe), 0);
      @(negedge clk);
      arb_clear = 1'b0;
      @(posedge clk); #1;
      chk("R11 restart after clear", int'(scl_oe), 1);
      @(negedge clk);
      run_req = 1'b0;
      repeat (60) @(posedge clk);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         failures = failures + 1;
         $display("FAIL watchdog act=%0d exp=%0d", WATCHDOG, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_freerun();
      t_stretch();
      t_cut();
      t_stop();
      t_arb();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule